// File: doc/BRIEF.md
# Three-Channel Up-Counting Timer

The block holds three independent up-counters that run from one shared clock. Each channel has its own prescaler, control bits, interval limit, three compare values, and interrupt status and enable registers. Software reaches all of these through a simple single-cycle 32-bit register port. A channel either runs freely and wraps at full scale, or runs in interval mode, where it goes back to zero once it reaches a programmed limit. Each channel drives its own interrupt line whenever a status event it has enabled is pending.

Registers are grouped by function. The three channels' copies of a register sit next to each other at a 4-byte stride, so channel c's copy of a group is at the group base plus 4*c. Reads are combinational from the address. A write takes effect at the rising clock edge while `bus_wr` is high.

Top module: `tri_timer`

## Requirements
- R1: After reset every counter-control register reads 0x21 (counter stopped, output-off flag set). Every other register reads 0, and all interrupt lines are low.
- R2: Group bases are clock control 0x00, counter control 0x0C, count (read-only) 0x18, interval 0x24, compare A/B/C 0x30/0x3C/0x48, status 0x54, and enable 0x60. Channel c adds 4*c. Unmapped or unaligned addresses read 0 and writes to them have no effect.
- R3: Counter-control bit 0 stops the counter, and the count holds while it is set. Bit 1 selects interval mode and bit 5 is a stored flag, both read back. Clearing bit 0 resumes counting from the held value.
- R4: Writing counter control with bit 4 set clears the count and the prescaler at that edge. Counting then restarts from 0. Bit 4 always reads 0.
- R5: In free-running mode the count goes from all ones (0xFFFF at the default 16-bit width) to 0 and sets status bit 4 (overflow).
- R6: In interval mode with a non-zero limit L, the count goes 0..L-1 and returns to 0 on the tick where it would reach L. That tick sets status bit 0, so an event occurs every L ticks.
- R7: Status bits 1, 2 and 3 are set on a tick whose new count value equals compare A, B or C. This includes a new value of 0 after a wrap or a restart.
- R8: Status bits stay set until software writes a 1 to them at the status address. Bits written 0 are unchanged. An event in the same cycle as the clearing write wins.
- R9: A channel's interrupt line is high exactly when some status bit and the matching enable bit are both set.
- R10: An interval limit of 1 gives an interval event on every tick. A limit of 0 makes interval mode behave like free-running wrap, with no bit-0 event.
- R11: Clock-control bit 0 enables the prescaler and bits [4:1] hold N. The counter then ticks once every 2^(N+1) clocks, so 0x09 divides by 32. With bit 0 clear it ticks every clock.
- R12: Writes and counting on one channel leave the other channels' registers and counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared input clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 3 | Per-channel interrupt, bit c for channel c |

## Verification
The bench builds the block with an 8-bit counter (`CNT_W = 8`) and the default 16-bit prescaler. The narrow counter makes full-scale wrap, overflow status and the compare-at-zero case reachable in a few hundred cycles, for free-running mode and for interval mode with a limit of 0. The default prescaler width keeps the divide-by-32 setting exactly as software would program it. Interval limits of 1 and 5 and a clearing write during continuous events cover restart timing and the rule that set beats clear.

// File: rtl/tri_timer.sv
module tri_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [2:0]  irq
);
  localparam int NCH = 3;
  localparam int NGRP = 9;
  localparam int NEV = 5;
  localparam int NCMP = 3;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam int G_CLK = 0, G_CTL = 1, G_VAL = 2, G_LIM = 3, G_CMP = 4, G_ST = 7, G_EN = 8;

  logic [4:0]       clkc  [NCH];
  logic [NCH-1:0]   c_stop, c_intv, c_woff;
  logic [CNT_W-1:0] cnt   [NCH];
  logic [CNT_W-1:0] lim   [NCH];
  logic [CNT_W-1:0] cmp   [NCH][NCMP];
  logic [NEV-1:0]   st    [NCH];
  logic [NEV-1:0]   en    [NCH];
  logic [PRE_W-1:0] pre   [NCH];

  logic [5:0]       off;
  logic [3:0]       grp;
  logic [1:0]       ch;
  logic [NGRP-1:0]  hit, gsel;
  logic [NCH-1:0]   csel;
  logic [NCH-1:0]   rst_hit, tick, restart;
  logic [PRE_W:0]   pmask [NCH];
  logic [CNT_W-1:0] inc   [NCH];
  logic [CNT_W-1:0] nxt   [NCH];
  logic [NEV-1:0]   ev    [NCH];
  logic             unused_bits;

  assign off  = bus_addr[7:2];
  assign grp  = 4'(off / 6'd3);
  assign ch   = 2'(off % 6'd3);
  assign hit  = (bus_addr[1:0] == 2'b00 && off < 6'd27) ? NGRP'(1) << grp : '0;
  assign gsel = bus_wr ? hit : '0;
  assign csel = NCH'(1) << ch;
  assign unused_bits = ^bus_wdata;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      rst_hit[i] = gsel[G_CTL] && csel[i] && bus_wdata[4];
      pmask[i]   = ((PRE_W+1)'(2) << clkc[i][4:1]) - (PRE_W+1)'(1);
      tick[i]    = !c_stop[i] && !rst_hit[i] &&
                   (!clkc[i][0] || (pre[i] & pmask[i][PRE_W-1:0]) == pmask[i][PRE_W-1:0]);
      inc[i]     = cnt[i] + CNT_W'(1);
      restart[i] = c_intv[i] && lim[i] != '0 && inc[i] == lim[i];
      nxt[i]     = restart[i] ? '0 : inc[i];
      ev[i][0]   = tick[i] && restart[i];
      ev[i][4]   = tick[i] && !restart[i] && cnt[i] == CMAX;
      for (int k = 0; k < NCMP; k++)
        ev[i][k+1] = tick[i] && nxt[i] == cmp[i][k];
      irq[i]     = |(st[i] & en[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_stop <= '1;
      c_intv <= '0;
      c_woff <= '1;
      for (int i = 0; i < NCH; i++) begin
        clkc[i] <= '0;
        cnt[i]  <= '0;
        lim[i]  <= '0;
        st[i]   <= '0;
        en[i]   <= '0;
        pre[i]  <= '0;
        for (int k = 0; k < NCMP; k++) cmp[i][k] <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (gsel[G_CLK] && csel[i]) clkc[i] <= bus_wdata[4:0];
        if (gsel[G_CTL] && csel[i]) begin
          c_stop[i] <= bus_wdata[0];
          c_intv[i] <= bus_wdata[1];
          c_woff[i] <= bus_wdata[5];
        end
        if (gsel[G_LIM] && csel[i]) lim[i] <= bus_wdata[CNT_W-1:0];
        for (int k = 0; k < NCMP; k++)
          if (gsel[G_CMP+k] && csel[i]) cmp[i][k] <= bus_wdata[CNT_W-1:0];
        if (gsel[G_EN] && csel[i]) en[i] <= bus_wdata[NEV-1:0];
        st[i] <= (st[i] & ~((gsel[G_ST] && csel[i]) ? bus_wdata[NEV-1:0] : '0)) | ev[i];
        if (rst_hit[i]) begin
          cnt[i] <= '0;
          pre[i] <= '0;
        end else if (!c_stop[i]) begin
          pre[i] <= pre[i] + PRE_W'(1);
          if (tick[i]) cnt[i] <= nxt[i];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (csel[i]) begin
        if (hit[G_CLK]) bus_rdata = 32'(clkc[i]);
        if (hit[G_CTL]) bus_rdata = 32'({c_woff[i], 3'b000, c_intv[i], c_stop[i]});
        if (hit[G_VAL]) bus_rdata = 32'(cnt[i]);
        if (hit[G_LIM]) bus_rdata = 32'(lim[i]);
        for (int k = 0; k < NCMP; k++)
          if (hit[G_CMP+k]) bus_rdata = 32'(cmp[i][k]);
        if (hit[G_ST]) bus_rdata = 32'(st[i]);
        if (hit[G_EN]) bus_rdata = 32'(en[i]);
      end
    end
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chk
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (c_stop[gi] && !rst_hit[gi]) |=> $stable(cnt[gi]));
    p_zero_r4: assert property (@(posedge clk) disable iff (rst)
      rst_hit[gi] |=> (cnt[gi] == '0 && pre[gi] == '0));
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      (tick[gi] && !restart[gi] && cnt[gi] == CMAX) |=> (cnt[gi] == '0 && st[gi][4]));
    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
      (tick[gi] && restart[gi]) |=> (cnt[gi] == '0 && st[gi][0]));
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (gsel[G_ST] && csel[gi] && bus_wdata[4:0] == 5'h1f && ev[gi] == '0) |=> st[gi] == '0);
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      !(gsel[G_ST] && csel[gi]) |=> ((st[gi] & $past(st[gi])) == $past(st[gi])));
  end
endmodule

// File: tb/tri_timer_test.sv
`timescale 1ns/1ps
module tri_timer_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;
  int total = 0;
  int bad = 0;
  logic [31:0] v;
  logic [31:0] hold0;

  tri_timer #(.CNT_W(8), .PRE_W(16)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    for (int c = 0; c < 3; c++) begin
      rd(8'(8'h0C + 4*c), v); chk("R1 ctl reset", v, 32'h21);
      rd(8'(8'h18 + 4*c), v); chk("R1 count reset", v, 0);
      rd(8'(8'h54 + 4*c), v); chk("R1 status reset", v, 0);
    end
    chk("R1 irq reset", 32'(irq), 0);
  endtask

  task automatic t_run_hold;
    wr(8'h0C, 32'h10);
    repeat (5) @(negedge clk);
    rd(8'h18, v); chk("R2 free count", v, 5);
    wr(8'h0C, 32'h01);
    rd(8'h18, v); chk("R3 stop edge", v, 7);
    repeat (10) @(negedge clk);
    rd(8'h18, v); chk("R3 held", v, 7);
    wr(8'h0C, 32'h00);
    repeat (3) @(negedge clk);
    rd(8'h18, v); chk("R3 resume", v, 10);
    rd(8'h0C, v); chk("R3 ctl readback", v, 0);
    wr(8'h0C, 32'h10);
    rd(8'h18, v); chk("R4 cleared", v, 0);
    repeat (4) @(negedge clk);
    rd(8'h18, v); chk("R4 restart", v, 4);
    rd(8'h0C, v); chk("R4 bit4 reads 0", v, 0);
  endtask

  task automatic t_map;
    rd(8'h1C, v); chk("R12 ch1 idle", v, 0);
    rd(8'h10, v); chk("R12 ch1 ctl", v, 32'h21);
    wr(8'h2C, 32'h55);
    rd(8'h2C, v); chk("R2 ch2 interval", v, 32'h55);
    rd(8'h24, v); chk("R2 ch0 interval", v, 0);
    rd(8'h6C, v); chk("R2 unmapped", v, 0);
    wr(8'h10, 32'h23);
    rd(8'h10, v); chk("R3 ctl 0x23", v, 32'h23);
    repeat (3) @(negedge clk);
    rd(8'h1C, v); chk("R3 ch1 stopped", v, 0);
  endtask

  task automatic t_wrap;
    wr(8'h0C, 32'h10);
    rd(8'h54, v); chk("R5 status clean", v, 0);
    repeat (255) @(negedge clk);
    rd(8'h18, v); chk("R5 full scale", v, 255);
    rd(8'h54, v); chk("R5 no early ovf", v, 0);
    @(negedge clk);
    rd(8'h18, v); chk("R5 wrapped", v, 0);
    rd(8'h54, v); chk("R7 ovf plus compares at 0", v, 32'h1E);
    chk("R9 disabled irq", 32'(irq[0]), 0);
    wr(8'h60, 32'h10);
    chk("R9 irq on", 32'(irq[0]), 1);
    wr(8'h54, 32'h02);
    rd(8'h54, v); chk("R8 partial clear", v, 32'h1C);
    chk("R9 irq still", 32'(irq[0]), 1);
    wr(8'h54, 32'h1C);
    rd(8'h54, v); chk("R8 cleared", v, 0);
    chk("R9 irq off", 32'(irq[0]), 0);
    wr(8'h0C, 32'h01);
  endtask

  task automatic t_interval;
    rd(8'h18, hold0);
    wr(8'h34, 3);
    wr(8'h40, 32'hEE);
    wr(8'h4C, 32'hEE);
    wr(8'h28, 5);
    wr(8'h64, 32'h01);
    wr(8'h10, 32'h12);
    repeat (3) @(negedge clk);
    rd(8'h1C, v); chk("R6 count 3", v, 3);
    rd(8'h58, v); chk("R7 compare A", v, 32'h02);
    chk("R9 irq1 masked", 32'(irq[1]), 0);
    repeat (2) @(negedge clk);
    rd(8'h1C, v); chk("R6 restart", v, 0);
    rd(8'h58, v); chk("R6 interval bit", v, 32'h03);
    chk("R9 irq1", 32'(irq[1]), 1);
    repeat (5) @(negedge clk);
    rd(8'h1C, v); chk("R6 period 5", v, 0);
    rd(8'h18, v); chk("R12 ch0 untouched", v, hold0);
    wr(8'h10, 32'h01);
  endtask

  task automatic t_limits;
    wr(8'h2C, 1);
    wr(8'h14, 32'h12);
    @(negedge clk);
    rd(8'h20, v); chk("R10 limit 1 count", v, 0);
    rd(8'h5C, v); chk("R10 limit 1 event", v, 32'h0F);
    wr(8'h5C, 32'h1F);
    rd(8'h5C, v); chk("R8 set wins", v, 32'h0F);
    wr(8'h14, 32'h01);
    wr(8'h2C, 0);
    wr(8'h5C, 32'h1F);
    rd(8'h5C, v); chk("R8 clear all", v, 0);
    wr(8'h14, 32'h12);
    repeat (255) @(negedge clk);
    rd(8'h20, v); chk("R10 limit 0 full", v, 255);
    @(negedge clk);
    rd(8'h20, v); chk("R10 limit 0 wrap", v, 0);
    rd(8'h5C, v); chk("R10 no interval bit", v, 32'h1E);
  endtask

  task automatic t_prescale;
    wr(8'h00, 32'h09);
    rd(8'h00, v); chk("R11 clk ctl", v, 32'h09);
    wr(8'h0C, 32'h10);
    repeat (31) @(negedge clk);
    rd(8'h18, v); chk("R11 before tick", v, 0);
    @(negedge clk);
    rd(8'h18, v); chk("R11 first tick", v, 1);
    repeat (64) @(negedge clk);
    rd(8'h18, v); chk("R11 div32", v, 3);
  endtask

  initial begin
    #4_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_run_hold();
    t_map();
    t_wrap();
    t_interval();
    t_limits();
    t_prescale();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule